// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block resolves read-after-write dependencies between back-to-back instructions in a five-stage load/store integer pipeline, so that an instruction in the execute stage does not have to wait for register-file writeback. It decodes the two source register numbers of the execute-stage instruction word. It decodes the destination register number of the instructions in the two downstream pipeline registers. It then steers each ALU operand to the value the program expects.

Each operand has three possible sources. The first is the value read from the register file. The second is the ALU result held in the execute/memory pipeline register. The third is the writeback value held in the memory/writeback pipeline register, which is either load data or an ALU result. The block drives a 2-bit select code for each operand and the resolved operand values. It also drives the store-data word, so a store whose data register was just produced carries the fresh value into the memory stage. The path is purely combinational. Detecting the load-use case and stalling for it belong to a separate hazard unit.

Top module: `fwd_unit`

## Requirements
- R1: Operand A uses the source register field in bits 25:21 of `ex_instr`, and operand B uses the field in bits 20:16.
- R2: A producer's destination register is taken from bits 15:11 when its opcode (bits 31:26) is 000000, and from bits 20:16 for any other opcode.
- R3: If the execute/memory producer has `exmem_regwrite` = 1 and its destination equals an operand's source, that operand's select is 2'b10 and its value is `exmem_alu_result`. With `exmem_regwrite` = 0 that producer never matches.
- R4: If the memory/writeback producer has `memwb_regwrite` = 1 and its destination equals an operand's source, the select is 2'b01 and the value is `memwb_wb_data`, unless R3 applies.
- R5: When both producers match the same operand, the execute/memory (younger) producer wins and the select is 2'b10.
- R6: With no qualifying match, the select is 2'b00 and the operand equals the register-file value (`rf_a_data` or `rf_b_data`).
- R7: A destination of register 0 is never forwarded, even with its write enable set.
- R8: An execute/memory producer whose opcode is the load opcode 100011 is never forwarded, because its ALU result is an address. The operand then falls back to the memory/writeback producer or to the register file.
- R9: `store_data` always equals the resolved operand B value, including when that value is forwarded.
- R10: Each operand is resolved independently, both may forward from the same producer, and the code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_instr | input | 32 | Instruction word in the execute stage |
| rf_a_data | input | 32 | Register-file value read for operand A |
| rf_b_data | input | 32 | Register-file value read for operand B |
| exmem_instr | input | 32 | Instruction word held in the execute/memory register |
| exmem_regwrite | input | 1 | Register-write enable of that instruction |
| exmem_alu_result | input | 32 | ALU result held in the execute/memory register |
| memwb_instr | input | 32 | Instruction word held in the memory/writeback register |
| memwb_regwrite | input | 1 | Register-write enable of that instruction |
| memwb_wb_data | input | 32 | Value about to be written back |
| sel_a | output | 2 | Operand A select: 00 file, 10 exec/mem, 01 mem/wb |
| sel_b | output | 2 | Operand B select, same coding |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |
| store_data | output | 32 | Data word passed on for a store |

## Verification
The bench places both producers on the same register. A design that ranked the older producer first would hand the ALU a stale value there. Register 0 is written with its enable set, to catch a unit that bypasses a hardwired zero. A load is placed in the execute/memory slot with a matching destination; a unit without that guard would feed the load address to the ALU. The bench also uses an R-type producer whose bits 20:16 match the consumer while its true destination does not, which exposes a destination decoder that ignores the opcode. A store with a freshly written data register checks that the store path sees the forwarded word and not the file value.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      SEL_FILE  = 2'b00,
      SEL_MEMWB = 2'b01,
      SEL_EXMEM = 2'b10
   } fwd_sel_e;

   localparam int unsigned DEF_XLEN   = 32;
   localparam int unsigned DEF_RAW    = 5;
   localparam int unsigned DEF_OPW    = 6;
   localparam int unsigned DEF_RD_LSB = 11;

   localparam logic [DEF_OPW-1:0] DEF_RTYPE_OP = 6'b000000;
   localparam logic [DEF_OPW-1:0] DEF_LOAD_OP  = 6'b100011;

endpackage

// File: rtl/fwd_field_decode.sv
module fwd_field_decode #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned RAW    = 5,
   parameter int unsigned OPW    = 6,
   parameter int unsigned RD_LSB = 11,
   parameter logic [OPW-1:0] RTYPE_OP = '0,
   parameter logic [OPW-1:0] LOAD_OP  = 6'b100011
) (
   input  logic [XLEN-1:0] word_i,
   output logic [RAW-1:0]  src_a_o,
   output logic [RAW-1:0]  src_b_o,
   output logic [RAW-1:0]  dest_o,
   output logic            is_load_o
);
   localparam int unsigned RT_LSB = RD_LSB + RAW;
   localparam int unsigned RS_LSB = RT_LSB + RAW;
   localparam int unsigned OP_LSB = RS_LSB + RAW;

   if (OP_LSB + OPW > XLEN) begin : g_bad_layout
      $error("fwd_field_decode: fields do not fit in the word");
   end

   logic [OPW-1:0] opcode;
   logic [RAW-1:0] rd_field;
   logic           is_rtype;

   assign opcode   = word_i[OP_LSB +: OPW];
   assign src_a_o  = word_i[RS_LSB +: RAW];
   assign src_b_o  = word_i[RT_LSB +: RAW];
   assign rd_field = word_i[RD_LSB +: RAW];
   assign is_rtype = (opcode == RTYPE_OP);

   always_comb begin
      if (is_rtype) dest_o = rd_field;
      else          dest_o = src_b_o;
   end

   assign is_load_o = (opcode == LOAD_OP);

endmodule

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int unsigned RAW       = 5,
   parameter bit          ZERO_WIRED = 1'b1
) (
   input  logic [RAW-1:0] src_i,
   input  logic [RAW-1:0] dest_i,
   input  logic           wr_en_i,
   input  logic           block_i,
   output logic           hit_o
);
   logic same;
   logic dest_live;

   assign same = (src_i == dest_i);

   if (ZERO_WIRED) begin : g_zero_wired
      assign dest_live = |dest_i;
   end else begin : g_zero_plain
      assign dest_live = 1'b1;
   end

   assign hit_o = wr_en_i & ~block_i & dest_live & same;

endmodule

// File: rtl/fwd_select.sv
module fwd_select
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          ANDOR_MUX  = 1'b0
) (
   input  logic            exmem_hit_i,
   input  logic            memwb_hit_i,
   input  logic [XLEN-1:0] file_val_i,
   input  logic [XLEN-1:0] exmem_val_i,
   input  logic [XLEN-1:0] memwb_val_i,
   output fwd_sel_e        sel_o,
   output logic [XLEN-1:0] val_o
);
   always_comb begin
      if (exmem_hit_i)      sel_o = SEL_EXMEM;
      else if (memwb_hit_i) sel_o = SEL_MEMWB;
      else                  sel_o = SEL_FILE;
   end

   if (ANDOR_MUX) begin : g_andor
      logic take_ex, take_wb, take_rf;
      assign take_ex = exmem_hit_i;
      assign take_wb = ~exmem_hit_i & memwb_hit_i;
      assign take_rf = ~exmem_hit_i & ~memwb_hit_i;
      assign val_o = ({XLEN{take_ex}} & exmem_val_i)
                   | ({XLEN{take_wb}} & memwb_val_i)
                   | ({XLEN{take_rf}} & file_val_i);
   end else begin : g_case
      always_comb begin
         unique case (sel_o)
            SEL_EXMEM: val_o = exmem_val_i;
            SEL_MEMWB: val_o = memwb_val_i;
            default:   val_o = file_val_i;
         endcase
      end
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN       = DEF_XLEN,
   parameter int unsigned RAW        = DEF_RAW,
   parameter int unsigned OPW        = DEF_OPW,
   parameter int unsigned RD_LSB     = DEF_RD_LSB,
   parameter logic [OPW-1:0] RTYPE_OP = DEF_RTYPE_OP,
   parameter logic [OPW-1:0] LOAD_OP  = DEF_LOAD_OP,
   parameter bit          ZERO_WIRED = 1'b1,
   parameter bit          ANDOR_MUX  = 1'b0
) (
   input  logic [XLEN-1:0] ex_instr,
   input  logic [XLEN-1:0] rf_a_data,
   input  logic [XLEN-1:0] rf_b_data,
   input  logic [XLEN-1:0] exmem_instr,
   input  logic            exmem_regwrite,
   input  logic [XLEN-1:0] exmem_alu_result,
   input  logic [XLEN-1:0] memwb_instr,
   input  logic            memwb_regwrite,
   input  logic [XLEN-1:0] memwb_wb_data,
   output logic [1:0]      sel_a,
   output logic [1:0]      sel_b,
   output logic [XLEN-1:0] opnd_a,
   output logic [XLEN-1:0] opnd_b,
   output logic [XLEN-1:0] store_data
);
   localparam int unsigned NOPND = 2;

   if (RAW < 1 || XLEN < 8) begin : g_bad_width
      $error("fwd_unit: register address or data width too small");
   end

   logic [RAW-1:0] ex_src [NOPND];
   logic [RAW-1:0] ex_dest_unused;
   logic           ex_load_unused;
   logic [RAW-1:0] exmem_dest, memwb_dest;
   logic [RAW-1:0] exmem_src_a_unused, exmem_src_b_unused;
   logic [RAW-1:0] memwb_src_a_unused, memwb_src_b_unused;
   logic           exmem_is_load, memwb_load_unused;

   fwd_field_decode #(
      .XLEN(XLEN), .RAW(RAW), .OPW(OPW), .RD_LSB(RD_LSB),
      .RTYPE_OP(RTYPE_OP), .LOAD_OP(LOAD_OP)
   ) u_dec_ex (
      .word_i   (ex_instr),
      .src_a_o  (ex_src[0]),
      .src_b_o  (ex_src[1]),
      .dest_o   (ex_dest_unused),
      .is_load_o(ex_load_unused)
   );

   fwd_field_decode #(
      .XLEN(XLEN), .RAW(RAW), .OPW(OPW), .RD_LSB(RD_LSB),
      .RTYPE_OP(RTYPE_OP), .LOAD_OP(LOAD_OP)
   ) u_dec_exmem (
      .word_i   (exmem_instr),
      .src_a_o  (exmem_src_a_unused),
      .src_b_o  (exmem_src_b_unused),
      .dest_o   (exmem_dest),
      .is_load_o(exmem_is_load)
   );

   fwd_field_decode #(
      .XLEN(XLEN), .RAW(RAW), .OPW(OPW), .RD_LSB(RD_LSB),
      .RTYPE_OP(RTYPE_OP), .LOAD_OP(LOAD_OP)
   ) u_dec_memwb (
      .word_i   (memwb_instr),
      .src_a_o  (memwb_src_a_unused),
      .src_b_o  (memwb_src_b_unused),
      .dest_o   (memwb_dest),
      .is_load_o(memwb_load_unused)
   );

   logic [XLEN-1:0] file_val [NOPND];
   fwd_sel_e        sel_v    [NOPND];
   logic [XLEN-1:0] res_v    [NOPND];

   assign file_val[0] = rf_a_data;
   assign file_val[1] = rf_b_data;

   for (genvar k = 0; k < NOPND; k++) begin : g_opnd
      logic hit_ex, hit_wb;

      fwd_match #(.RAW(RAW), .ZERO_WIRED(ZERO_WIRED)) u_m_ex (
         .src_i  (ex_src[k]),
         .dest_i (exmem_dest),
         .wr_en_i(exmem_regwrite),
         .block_i(exmem_is_load),
         .hit_o  (hit_ex)
      );

      fwd_match #(.RAW(RAW), .ZERO_WIRED(ZERO_WIRED)) u_m_wb (
         .src_i  (ex_src[k]),
         .dest_i (memwb_dest),
         .wr_en_i(memwb_regwrite),
         .block_i(1'b0),
         .hit_o  (hit_wb)
      );

      fwd_select #(.XLEN(XLEN), .ANDOR_MUX(ANDOR_MUX)) u_sel (
         .exmem_hit_i(hit_ex),
         .memwb_hit_i(hit_wb),
         .file_val_i (file_val[k]),
         .exmem_val_i(exmem_alu_result),
         .memwb_val_i(memwb_wb_data),
         .sel_o      (sel_v[k]),
         .val_o      (res_v[k])
      );
   end

   assign sel_a      = sel_v[0];
   assign sel_b      = sel_v[1];
   assign opnd_a     = res_v[0];
   assign opnd_b     = res_v[1];
   assign store_data = res_v[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned RAW    = 5,
   parameter int unsigned RD_LSB = 11
) (
   input logic [XLEN-1:0] ex_instr,
   input logic [XLEN-1:0] rf_a_data,
   input logic [XLEN-1:0] rf_b_data,
   input logic            exmem_regwrite,
   input logic [XLEN-1:0] exmem_alu_result,
   input logic            memwb_regwrite,
   input logic [XLEN-1:0] memwb_wb_data,
   input logic [1:0]      sel_a,
   input logic [1:0]      sel_b,
   input logic [XLEN-1:0] opnd_a,
   input logic [XLEN-1:0] opnd_b
);
   localparam int unsigned RT_LSB = RD_LSB + RAW;
   localparam int unsigned RS_LSB = RT_LSB + RAW;

   always_comb begin
      a_r10_sel_legal: assert (sel_a != 2'b11 && sel_b != 2'b11)
         else $error("select code 11 seen");
      a_r6_file_path: assert (sel_a != 2'b00 || opnd_a == rf_a_data)
         else $error("operand A not the file value under select 00");
      a_r3_exmem_path: assert (sel_b != 2'b10 ||
                               (exmem_regwrite && opnd_b == exmem_alu_result))
         else $error("operand B exec/mem path wrong");
      a_r4_memwb_path: assert (sel_a != 2'b01 ||
                               (memwb_regwrite && opnd_a == memwb_wb_data))
         else $error("operand A mem/wb path wrong");
      a_r7_zero_src: assert (ex_instr[RS_LSB +: RAW] != '0 || sel_a == 2'b00)
         else $error("register 0 forwarded to operand A");
      a_r6_file_b: assert (sel_b != 2'b00 || opnd_b == rf_b_data)
         else $error("operand B not the file value under select 00");
   end

endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .RAW(RAW), .RD_LSB(RD_LSB)) u_chk (
   .ex_instr        (ex_instr),
   .rf_a_data       (rf_a_data),
   .rf_b_data       (rf_b_data),
   .exmem_regwrite  (exmem_regwrite),
   .exmem_alu_result(exmem_alu_result),
   .memwb_regwrite  (memwb_regwrite),
   .memwb_wb_data   (memwb_wb_data),
   .sel_a           (sel_a),
   .sel_b           (sel_b),
   .opnd_a          (opnd_a),
   .opnd_b          (opnd_b)
);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [31:0] ex_instr, rf_a_data, rf_b_data;
   logic [31:0] exmem_instr, exmem_alu_result, memwb_instr, memwb_wb_data;
   logic        exmem_regwrite, memwb_regwrite;
   logic [1:0]  sel_a, sel_b;
   logic [31:0] opnd_a, opnd_b, store_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam logic [31:0] RFA = 32'hAAAA_0001;
   localparam logic [31:0] RFB = 32'hBBBB_0002;
   localparam logic [31:0] EXV = 32'hE0E0_1234;
   localparam logic [31:0] WBV = 32'h5B5B_9876;

   fwd_unit u0 (.*);

   function automatic logic [31:0] rtype(input int rs, input int rt, input int rd);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'b100000};
   endfunction

   function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt);
      return {op, 5'(rs), 5'(rt), 16'h0040};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      ex_instr = '0; exmem_instr = '0; memwb_instr = '0;
      exmem_regwrite = 1'b0; memwb_regwrite = 1'b0;
      rf_a_data = RFA; rf_b_data = RFB;
      exmem_alu_result = EXV; memwb_wb_data = WBV;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic t_idle();
      idle(); settle();
      chk("R6 idle sel_a", {30'd0, sel_a}, 32'd0);
      chk("R6 idle opnd_a", opnd_a, RFA);
      chk("R6 idle opnd_b", opnd_b, RFB);
   endtask

   task automatic t_exmem_basic();
      idle();
      ex_instr = rtype(5, 7, 9);
      exmem_instr = rtype(1, 2, 5); exmem_regwrite = 1'b1;
      settle();
      chk("R1 R3 sel_a from rs field", {30'd0, sel_a}, 32'd2);
      chk("R3 opnd_a", opnd_a, EXV);
      chk("R1 sel_b untouched", {30'd0, sel_b}, 32'd0);
      exmem_regwrite = 1'b0; settle();
      chk("R3 no write enable", {30'd0, sel_a}, 32'd0);
   endtask

   task automatic t_memwb_load();
      idle();
      ex_instr = itype(6'b101011, 3, 9);
      memwb_instr = itype(6'b100011, 1, 9); memwb_regwrite = 1'b1;
      settle();
      chk("R2 R4 sel_b from I-type dest", {30'd0, sel_b}, 32'd1);
      chk("R4 opnd_b", opnd_b, WBV);
      chk("R9 store_data from mem/wb", store_data, WBV);
   endtask

   task automatic t_priority();
      idle();
      ex_instr = rtype(12, 4, 1);
      exmem_instr = rtype(0, 0, 12); exmem_regwrite = 1'b1;
      memwb_instr = rtype(0, 0, 12); memwb_regwrite = 1'b1;
      settle();
      chk("R5 younger wins sel", {30'd0, sel_a}, 32'd2);
      chk("R5 younger wins data", opnd_a, EXV);
   endtask

   task automatic t_zero();
      idle();
      ex_instr = rtype(0, 0, 3);
      exmem_instr = rtype(1, 1, 0); exmem_regwrite = 1'b1;
      memwb_instr = itype(6'b100011, 2, 0); memwb_regwrite = 1'b1;
      settle();
      chk("R7 reg0 sel_a", {30'd0, sel_a}, 32'd0);
      chk("R7 reg0 sel_b", {30'd0, sel_b}, 32'd0);
      chk("R7 reg0 opnd_b", opnd_b, RFB);
   endtask

   task automatic t_load_block();
      idle();
      ex_instr = rtype(4, 6, 1);
      exmem_instr = itype(6'b100011, 2, 4); exmem_regwrite = 1'b1;
      settle();
      chk("R8 load in exec/mem not used", {30'd0, sel_a}, 32'd0);
      chk("R8 file value kept", opnd_a, RFA);
      memwb_instr = rtype(0, 0, 4); memwb_regwrite = 1'b1;
      settle();
      chk("R8 falls back to mem/wb", {30'd0, sel_a}, 32'd1);
      chk("R8 mem/wb data", opnd_a, WBV);
   endtask

   task automatic t_rtype_dest();
      idle();
      ex_instr = rtype(3, 8, 1);
      exmem_instr = rtype(1, 3, 6); exmem_regwrite = 1'b1;
      settle();
      chk("R2 R-type dest is bits 15:11", {30'd0, sel_a}, 32'd0);
      ex_instr = rtype(6, 8, 1); settle();
      chk("R2 R-type true dest forwards", {30'd0, sel_a}, 32'd2);
   endtask

   task automatic t_both_operands();
      idle();
      ex_instr = rtype(10, 10, 2);
      exmem_instr = rtype(1, 1, 10); exmem_regwrite = 1'b1;
      settle();
      chk("R10 sel_a same producer", {30'd0, sel_a}, 32'd2);
      chk("R10 sel_b same producer", {30'd0, sel_b}, 32'd2);
      chk("R9 store_data forwarded", store_data, EXV);
      ex_instr = rtype(10, 11, 2);
      memwb_instr = rtype(1, 1, 11); memwb_regwrite = 1'b1;
      settle();
      chk("R10 independent sel_a", {30'd0, sel_a}, 32'd2);
      chk("R10 independent sel_b", {30'd0, sel_b}, 32'd1);
   endtask

   task automatic t_sweep();
      for (int r = 1; r < 32; r++) begin
         idle();
         ex_instr = rtype(r, (r + 1) % 32, 0);
         memwb_instr = rtype(0, 0, r); memwb_regwrite = 1'b1;
         settle();
         chk("R4 sweep sel_a", {30'd0, sel_a}, 32'd1);
      end
   endtask

   initial begin
      repeat (1000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      t_idle();
      t_exmem_basic();
      t_memwb_load();
      t_priority();
      t_zero();
      t_load_block();
      t_rtype_dest();
      t_both_operands();
      t_sweep();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule